// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address from a requester into a data word fetched from physical memory. It uses a page table that lives in memory and has one level. For each request it splits the virtual address into a page number and an offset. It forms the address of the table entry from a software-written base register and the page number, and reads that entry over a shared memory request/response port. It then checks the entry's valid bit.

A valid entry supplies the physical page number. The block joins it with the unchanged offset, issues a second memory read at that physical address and hands the returned word back to the requester. An invalid entry causes no second access. Instead the block pulses a page-fault signal that carries the faulting virtual address. After the fault has been handled, the same address can be presented again, and the walk reads the entry afresh. Only one translation is in flight at a time. The block keeps no cached copy of any entry.

Top module: `pt_walker`

## Requirements
- R1: After reset the table base is zero, `req_ready` is high, and `mem_req_valid`, `rsp_valid` and `fault_valid` are low.
- R2: The first memory read of a walk is at the entry address. This is the table base plus four times the page number, where the page number is `req_vaddr[31:12]`.
- R3: On a hit, the second memory read is at the entry's bits 31:12 placed above `req_vaddr[11:0]`. Entry bits 11:1 have no effect on it.
- R4: A hit makes exactly two memory reads, the entry read first and the data read second. While `mem_req_ready` is low, the request stays valid and its address stays stable.
- R5: On a hit, `rsp_valid` is high for exactly one cycle, with `rsp_data` equal to the word returned by the data read.
- R6: An entry with bit 0 equal to 0 makes no data read. Instead `fault_valid` pulses for one cycle with `fault_vaddr` equal to the requested virtual address.
- R7: Presenting a faulted address again re-reads the entry from memory, so a corrected entry gives a normal hit.
- R8: From the cycle after a request is accepted until the cycle after its response or fault, `req_ready` is low.
- R9: A base write during a walk leaves that walk's entry address unchanged. It applies from the next accepted request.
- R10: `rsp_valid` and `fault_valid` are never high together, and `req_ready` is high again in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse: data word ready |
| rsp_data | output | 32 | Data word read at the physical address |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_vaddr | output | 32 | Virtual address that faulted |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Memory read address (entry or physical) |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |

## Verification
The bound checker watches every cycle for the following:
- the entry address of each walk, formed from the base seen at acceptance;
- the offset carried into the data address;
- the number of memory reads before a response or a fault;
- the hold of a stalled memory request;
- the busy window of `req_ready`;
- the single-cycle, mutually exclusive response and fault pulses.

Only the bench's scenarios can show the remaining behaviour: the data word returned for a given table content, the full physical address built from the entry's page-number field, recovery on retry after the entry is fixed in memory, and the deferred effect of a base write made during a walk. The bench runs these under varied memory latency and ready stalls.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_PTE_REQ   = 3'd1,
    ST_PTE_WAIT  = 3'd2,
    ST_DATA_REQ  = 3'd3,
    ST_DATA_WAIT = 3'd4,
    ST_RESP      = 3'd5,
    ST_FAULT     = 3'd6
  } walk_state_e;

  // log2 of the entry size in bytes, used as the index shift
  function automatic int entry_shift(input int entry_bits);
    return $clog2(entry_bits / 8);
  endfunction

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] base_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
    end else if (we_i) begin
      base_o <= wdata_i;
    end
  end

endmodule

// File: rtl/pt_addr_calc.sv
module pt_addr_calc #(
  parameter int OFS_W     = 12,
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 0,
  localparam int PA_W     = PPN_W + OFS_W
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [PTE_W-1:0] pte_i,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [PA_W-1:0]  phys_addr_o,
  output logic             pte_valid_o
);

  localparam int SH    = pt_walk_pkg::entry_shift(PTE_W);
  localparam int IDX_W = VPN_W + SH;

  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  idx_ext;
  logic [PTE_W-1:0] unused_pte;

  assign idx = IDX_W'(vpn_i) << SH;

  generate
    if (PA_W > IDX_W) begin : g_ext
      assign idx_ext = {{(PA_W - IDX_W){1'b0}}, idx};
    end else begin : g_trunc
      assign idx_ext = idx[PA_W-1:0];
    end
  endgenerate

  assign pte_addr_o  = base_i + idx_ext;
  assign phys_addr_o = {pte_i[PTE_W-1 -: PPN_W], ofs_i};
  assign pte_valid_o = pte_i[VALID_BIT];
  assign unused_pte  = pte_i;

endmodule

// File: rtl/pt_walk_ctl.sv
module pt_walk_ctl
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  output logic              req_ready_o,
  input  logic [PA_W-1:0]   pte_addr_i,
  input  logic [PA_W-1:0]   phys_addr_i,
  input  logic              pte_valid_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              fault_valid_o,
  output logic [VA_W-1:0]   cur_va_o
);

  walk_state_e state, state_n;

  logic accept;
  logic pte_hit;

  assign accept  = (state == ST_IDLE) && req_valid_i;
  assign pte_hit = (state == ST_PTE_WAIT) && mem_rsp_valid_i && pte_valid_i;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:      if (req_valid_i)     state_n = ST_PTE_REQ;
      ST_PTE_REQ:   if (mem_req_ready_i) state_n = ST_PTE_WAIT;
      ST_PTE_WAIT:  if (mem_rsp_valid_i) state_n = pte_valid_i ? ST_DATA_REQ : ST_FAULT;
      ST_DATA_REQ:  if (mem_req_ready_i) state_n = ST_DATA_WAIT;
      ST_DATA_WAIT: if (mem_rsp_valid_i) state_n = ST_RESP;
      ST_RESP:      state_n = ST_IDLE;
      ST_FAULT:     state_n = ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
  end

  // output flags are registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      req_ready_o     <= 1'b1;
      mem_req_valid_o <= 1'b0;
      rsp_valid_o     <= 1'b0;
      fault_valid_o   <= 1'b0;
      cur_va_o        <= '0;
      mem_req_addr_o  <= '0;
      rsp_data_o      <= '0;
    end else begin
      state           <= state_n;
      req_ready_o     <= (state_n == ST_IDLE);
      mem_req_valid_o <= (state_n == ST_PTE_REQ) || (state_n == ST_DATA_REQ);
      rsp_valid_o     <= (state_n == ST_RESP);
      fault_valid_o   <= (state_n == ST_FAULT);
      if (accept) begin
        cur_va_o       <= req_vaddr_i;
        mem_req_addr_o <= pte_addr_i;
      end
      if (pte_hit) begin
        mem_req_addr_o <= phys_addr_i;
      end
      if ((state == ST_DATA_WAIT) && mem_rsp_valid_i) begin
        rsp_data_o <= mem_rsp_data_i;
      end
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W      = 32,
  parameter int OFS_W     = 12,
  parameter int PPN_W     = 20,
  parameter int PTE_W     = 32,
  parameter int VALID_BIT = 0,
  localparam int PA_W     = PPN_W + OFS_W,
  localparam int VPN_W    = VA_W - OFS_W,
  localparam int DATA_W   = PTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [PA_W-1:0]   base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fault_valid,
  output logic [VA_W-1:0]   fault_vaddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] pte_addr;
  logic [PA_W-1:0] phys_addr;
  logic            pte_valid;
  logic [VA_W-1:0] cur_va;

  pt_base_reg #(.AW(PA_W)) base_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (base_we),
    .wdata_i (base_wdata),
    .base_o  (base_q)
  );

  // entry address uses the incoming request; physical address uses the held one
  pt_addr_calc #(
    .OFS_W     (OFS_W),
    .VPN_W     (VPN_W),
    .PPN_W     (PPN_W),
    .PTE_W     (PTE_W),
    .VALID_BIT (VALID_BIT)
  ) calc_i (
    .base_i      (base_q),
    .vpn_i       (req_vaddr[VA_W-1:OFS_W]),
    .ofs_i       (cur_va[OFS_W-1:0]),
    .pte_i       (mem_rsp_data),
    .pte_addr_o  (pte_addr),
    .phys_addr_o (phys_addr),
    .pte_valid_o (pte_valid)
  );

  pt_walk_ctl #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .DATA_W (DATA_W)
  ) ctl_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid_i     (req_valid),
    .req_vaddr_i     (req_vaddr),
    .req_ready_o     (req_ready),
    .pte_addr_i      (pte_addr),
    .phys_addr_i     (phys_addr),
    .pte_valid_i     (pte_valid),
    .mem_req_valid_o (mem_req_valid),
    .mem_req_ready_i (mem_req_ready),
    .mem_req_addr_o  (mem_req_addr),
    .mem_rsp_valid_i (mem_rsp_valid),
    .mem_rsp_data_i  (mem_rsp_data),
    .rsp_valid_o     (rsp_valid),
    .rsp_data_o      (rsp_data),
    .fault_valid_o   (fault_valid),
    .cur_va_o        (cur_va)
  );

  assign fault_vaddr = cur_va;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W   = 32,
  parameter int OFS_W  = 12,
  parameter int PA_W   = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              base_we,
  input logic [PA_W-1:0]   base_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              fault_valid,
  input logic [VA_W-1:0]   fault_vaddr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data
);

  localparam int SH = pt_walk_pkg::entry_shift(DATA_W);

  logic [PA_W-1:0]   base_m;
  logic [PA_W-1:0]   exp_pte;
  logic [VA_W-1:0]   acc_va;
  logic [1:0]        hs_cnt;
  logic              acc;
  logic [DATA_W-1:0] unused_chk;

  assign acc        = req_valid && req_ready;
  assign unused_chk = rsp_data ^ mem_rsp_data ^ {{(DATA_W-1){1'b0}}, mem_rsp_valid};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_m  <= '0;
      exp_pte <= '0;
      acc_va  <= '0;
      hs_cnt  <= '0;
    end else begin
      if (base_we) base_m <= base_wdata;
      if (acc) begin
        acc_va  <= req_vaddr;
        exp_pte <= base_m + (PA_W'(req_vaddr[VA_W-1:OFS_W]) << SH);
        hs_cnt  <= '0;
      end else if (mem_req_valid && mem_req_ready) begin
        hs_cnt <= hs_cnt + 2'd1;
      end
    end
  end

  // R2 / R9: first read of a walk uses the base seen at acceptance
  p_pte_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && hs_cnt == 2'd0) |-> (mem_req_addr == exp_pte));

  p_phys_ofs_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && hs_cnt == 2'd1) |-> (mem_req_addr[OFS_W-1:0] == acc_va[OFS_W-1:0]));

  p_hit_reads_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (hs_cnt == 2'd2));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_fault_reads_r6: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (hs_cnt == 2'd1 && fault_vaddr == acc_va));

  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);

  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    acc |=> !req_ready);

  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && fault_valid));

  p_ready_back_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || fault_valid) |=> req_ready);

endmodule

bind pt_walker pt_walker_chk #(
  .VA_W   (VA_W),
  .OFS_W  (OFS_W),
  .PA_W   (PA_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .base_we       (base_we),
  .base_wdata    (base_wdata),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .rsp_valid     (rsp_valid),
  .rsp_data      (rsp_data),
  .fault_valid   (fault_valid),
  .fault_vaddr   (fault_vaddr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        fault_valid;
  logic [31:0] fault_vaddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;
  logic [31:0] cur_tbase = '0;
  bit          fix_en = 0;
  logic [19:0] fix_vpn = '0;
  int          lat_cfg = 0;
  bit          stall_cfg = 0;
  logic [31:0] log_q[$];

  always #5 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fault_valid(fault_valid), .fault_vaddr(fault_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // table entry: page number in 31:12, junk in 11:1, valid in bit 0
  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    logic [19:0] ppn;
    logic        v;
    ppn = (vpn * 20'd7 + 20'd3) & 20'h3FFFF;
    v   = ((vpn % 5) != 0) || (fix_en && vpn == fix_vpn);
    return {ppn, 11'h5A5, v};
  endfunction

  function automatic logic [31:0] mem_of(input logic [31:0] a);
    logic [31:0] d;
    d = a - cur_tbase;
    if (d < 32'h0040_0000) return pte_of(d[21:2]);
    return a ^ 32'h5A3C_0F96;
  endfunction

  // memory model: logs accepted addresses, answers after lat_cfg cycles
  initial begin
    bit          pend = 0;
    int          wcnt = 0;
    int          cyc = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(posedge clk);
      if (mem_req_valid && mem_req_ready) begin
        pend  = 1;
        paddr = mem_req_addr;
        wcnt  = lat_cfg;
        log_q.push_back(mem_req_addr);
      end
      #1;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_of(paddr);
          pend = 0;
        end else begin
          wcnt--;
        end
      end
      mem_req_ready = stall_cfg ? ((cyc % 3) == 2) : 1'b1;
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic write_base(input logic [31:0] v);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic run_xlate(input logic [31:0] va, input logic [31:0] tb, input int lat, input bit stall);
    logic [19:0] vpn;
    logic [31:0] pte, pa, expd;
    bit          flt, busy_ok;
    int          waited;
    vpn  = va[31:12];
    pte  = pte_of(vpn);
    flt  = !pte[0];
    pa   = {pte[31:12], va[11:0]};
    expd = mem_of(pa);
    lat_cfg = lat;
    stall_cfg = stall;
    log_q.delete();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = ~va;
    busy_ok = 1;
    waited = 0;
    while (!(rsp_valid || fault_valid) && waited < 500) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      waited++;
    end
    chk(busy_ok, "R8 ready low during walk", {31'd0, busy_ok}, 32'd1);
    chk(!(rsp_valid && fault_valid), "R10 exclusive", {30'd0, rsp_valid, fault_valid}, 32'd0);
    chk(fault_valid == flt, "R6 outcome", {31'd0, fault_valid}, {31'd0, flt});
    if (log_q.size() >= 1)
      chk(log_q[0] == tb + {10'd0, vpn, 2'b00}, "R2 entry address", log_q[0], tb + {10'd0, vpn, 2'b00});
    if (!flt) begin
      chk(rsp_valid && rsp_data == expd, "R5 data", rsp_data, expd);
      chk(log_q.size() == 2, "R4 two reads", log_q.size(), 32'd2);
      if (log_q.size() >= 2) chk(log_q[1] == pa, "R3 physical address", log_q[1], pa);
    end else begin
      chk(fault_vaddr == va, "R6 fault vaddr", fault_vaddr, va);
      chk(log_q.size() == 1, "R6 no data read", log_q.size(), 32'd1);
    end
    @(negedge clk);
    chk(!rsp_valid && !fault_valid && req_ready, "R10 pulse end",
        {29'd0, rsp_valid, fault_valid, req_ready}, 32'd1);
  endtask

  initial begin
    logic [31:0] va;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid && !fault_valid, "R1 reset outputs",
        {28'd0, req_ready, mem_req_valid, rsp_valid, fault_valid}, 32'h8);

    // R1: base is zero after reset, so page 1's entry sits at address 4
    cur_tbase = 32'h0;
    run_xlate(32'h0000_1ABC, 32'h0, 0, 0);
    chk(log_q.size() >= 1 && log_q[0] == 32'h4, "R1 zero base", log_q.size() >= 1 ? log_q[0] : 32'hX, 32'h4);

    write_base(32'h8000_0000);
    cur_tbase = 32'h8000_0000;
    for (int i = 0; i < 160; i++) begin
      logic [19:0] vpn;
      logic [11:0] ofs;
      if (i == 80) begin
        write_base(32'h9000_0000);
        cur_tbase = 32'h9000_0000;
      end
      vpn = (i == 0) ? 20'h0 : (i == 1) ? 20'hFFFFF : 20'((i * 37 + 5) * 977);
      ofs = (i == 0) ? 12'h000 : (i == 1) ? 12'hFFF : 12'(i * 113);
      run_xlate({vpn, ofs}, cur_tbase, i % 4, (i % 3) == 0);
    end

    // R7: fault, fix the entry, retry the same address
    fix_en = 0;
    va = {20'd10, 12'h123};
    run_xlate(va, cur_tbase, 1, 0);
    fix_vpn = 20'd10;
    fix_en = 1;
    run_xlate(va, cur_tbase, 2, 1);
    chk(log_q.size() == 2 && log_q[0] == cur_tbase + 32'd40, "R7 retry re-reads entry",
        log_q.size() >= 1 ? log_q[0] : 32'hX, cur_tbase + 32'd40);

    // R9: base write in the middle of a walk
    va = {20'h0ABCD, 12'h456};
    fork
      run_xlate(va, 32'h9000_0000, 3, 1);
      begin
        repeat (3) @(negedge clk);
        write_base(32'hA000_0000);
      end
    join
    chk(log_q.size() >= 1 && log_q[0] == 32'h9000_0000 + {10'd0, 20'h0ABCD, 2'b00}, "R9 old base kept",
        log_q.size() >= 1 ? log_q[0] : 32'hX, 32'h9000_0000 + {10'd0, 20'h0ABCD, 2'b00});
    cur_tbase = 32'hA000_0000;
    run_xlate(va, 32'hA000_0000, 0, 0);
    chk(log_q.size() >= 1 && log_q[0] == 32'hA000_0000 + {10'd0, 20'h0ABCD, 2'b00}, "R9 new base applied",
        log_q.size() >= 1 ? log_q[0] : 32'hX, 32'hA000_0000 + {10'd0, 20'h0ABCD, 2'b00});

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule